// File: doc/BRIEF.md
# History-Indexed Indirect Target Predictor

This block guesses where a register-indirect branch (a switch dispatch, a virtual call, a jump through a table of function pointers) will go next. It makes no taken/not-taken guess. It only supplies a target address. Targets live in a table of 256 entries. The row for a branch is picked by mixing the branch address with a global record of recent conditional outcomes, so one indirect branch can hold a different target under each history.

A lookup presents a PC with a valid strobe. In the same cycle the block answers with a hit flag and a target, so the front end can use the target as the next fetch address on the following edge. The lookup also exposes the history value it used. The pipeline carries that snapshot with the branch and hands it back on the update port together with the resolved PC and target, and the update then rewrites the row the lookup read.

Resolved conditional branches feed the history through a separate shift input. A mode input turns off the history mixing so the table is indexed by PC alone. In that mode it predicts the last resolved target of each branch, which gives a baseline for comparison.

Top module: `ind_tgt_pred`

## Requirements
- R1: A lookup is purely combinational: in the cycle `lookupValid` is high, `lookupHit` and `lookupTarget` reflect the table as written by the previous clock edge. With `lookupValid` low, `lookupHit` is 0 and `lookupTarget` is 0.
- R2: In hashed mode the row index is `pc[9:2] XOR history[7:0]`. The tag is 6 bits: bit `i mod 6` of the tag is the XOR of every bit `i` of the 24-bit value `{pc[31:10], pc[1:0]}`.
- R3: A lookup misses when the selected row is invalid or its tag differs from the lookup tag. After reset every row is invalid.
- R4: When `updateValid` is high at a clock edge, the row chosen by `updatePc`, `updateHist` and the current mode gets the resolved target, the update tag and the valid flag.
- R5: The 8-bit history resets to 0. On each edge with `condValid` high it shifts left by one with `condTaken` (taken = 1) entering bit 0. Otherwise it holds. `lookupHist` shows its current value.
- R6: With `indexByPcOnly` = 1 the index is `pc[9:2]` and the history has no effect on which row is read or written.
- R7: A lookup and an update to the same row in the same cycle return the row's old contents. The new target is visible from the next cycle on.
- R8: One branch PC updated under two different histories keeps both targets, and each is returned when its history is presented again.
- R9: With `updateValid` low, values on the update inputs change no row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| indexByPcOnly | input | 1 | 1 selects PC-only indexing (baseline mode) |
| lookupValid | input | 1 | Lookup request |
| lookupPc | input | 32 | Address of the indirect branch being fetched |
| lookupHit | output | 1 | Valid tag-matching row found |
| lookupTarget | output | 32 | Predicted target, 0 on miss |
| lookupHist | output | 8 | History value in use for this cycle's lookup |
| updateValid | input | 1 | Resolved indirect branch write request |
| updatePc | input | 32 | Address of the resolved branch |
| updateTarget | input | 32 | Resolved target |
| updateHist | input | 8 | History snapshot taken at prediction time |
| condValid | input | 1 | A conditional branch resolved this cycle |
| condTaken | input | 1 | Its outcome, 1 = taken |

## Verification
The checker watches several things on every cycle. It confirms that the history shifts or holds exactly as the shift strobe dictates, that no hit appears without a lookup, and that the outputs are never unknown. It also checks that a write is readable on the very next cycle for the same PC, history and mode. Other behaviours depend on the table's longer-lived contents, and only the bench scenarios can show them. These are the coexistence of two targets for one branch under different histories, tag-mismatch misses on aliasing PCs, the old-data result of a same-row read and write, the absence of history influence in baseline mode, and the inert update port. The bench's behavioural table model covers them along with a long mixed random stream.

// File: rtl/itp_pkg.sv
package itp_pkg;

  // Strobes passed from the control half to the table datapath.
  typedef struct packed {
    logic rdEn;
    logic wrEn;
  } itpStrobes_t;

  typedef enum logic {
    IDX_HASHED  = 1'b0,
    IDX_PC_ONLY = 1'b1
  } itpIdxMode_e;

endpackage

// File: rtl/itp_ctrl.sv
module itp_ctrl
  import itp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               indexByPcOnly,
  input  logic               lookupValid,
  input  logic [PC_W-1:0]    lookupPc,
  input  logic               updateValid,
  input  logic [PC_W-1:0]    updatePc,
  input  logic [HIST_W-1:0]  updateHist,
  input  logic               condValid,
  input  logic               condTaken,
  output logic [HIST_W-1:0]  histQ,
  output logic [IDX_W-1:0]   rdIdx,
  output logic [TAG_W-1:0]   rdTag,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [TAG_W-1:0]   wrTag,
  output itpStrobes_t        strobes
);

  // Word-aligned PC: index comes from bits above the two byte-offset bits.
  localparam int ALIGN  = 2;
  localparam int REST_W = PC_W - IDX_W;

  itpIdxMode_e mode;
  assign mode = itpIdxMode_e'(indexByPcOnly);

  // Global history: shift left, newest outcome at bit 0.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      histQ <= '0;
    end else if (condValid) begin
      histQ <= {histQ[HIST_W-2:0], condTaken};
    end
  end

  function automatic logic [IDX_W-1:0] formIdx(input logic [PC_W-1:0] pc,
                                               input logic [HIST_W-1:0] h,
                                               input itpIdxMode_e m);
    logic [IDX_W-1:0] idx;
    idx = pc[IDX_W+ALIGN-1:ALIGN];
    if (m == IDX_HASHED) begin
      for (int i = 0; i < IDX_W; i++) begin
        if (i < HIST_W) idx[i] = idx[i] ^ h[i];
      end
    end
    return idx;
  endfunction

  // Tag folds every PC bit outside the index field into TAG_W bits.
  function automatic logic [TAG_W-1:0] formTag(input logic [PC_W-1:0] pc);
    logic [REST_W-1:0] rest;
    logic [TAG_W-1:0]  tag;
    rest = {pc[PC_W-1:IDX_W+ALIGN], pc[ALIGN-1:0]};
    tag  = '0;
    for (int i = 0; i < REST_W; i++) begin
      tag[i % TAG_W] = tag[i % TAG_W] ^ rest[i];
    end
    return tag;
  endfunction

  always_comb begin
    rdIdx        = formIdx(lookupPc, histQ, mode);
    rdTag        = formTag(lookupPc);
    wrIdx        = formIdx(updatePc, updateHist, mode);
    wrTag        = formTag(updatePc);
    strobes.rdEn = lookupValid;
    strobes.wrEn = updateValid;
  end

endmodule

// File: rtl/itp_table.sv
module itp_table
  import itp_pkg::*;
#(
  parameter int TGT_W = 32,
  parameter int IDX_W = 8,
  parameter int TAG_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  itpStrobes_t       strobes,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [TAG_W-1:0]  rdTag,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [TGT_W-1:0]  wrTarget,
  output logic              hit,
  output logic [TGT_W-1:0]  target
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ [ENTRIES];
  logic [TGT_W-1:0]   tgtQ [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobes.wrEn) begin
      validQ[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      tagQ[wrIdx] <= wrTag;
      tgtQ[wrIdx] <= wrTarget;
    end
  end

  // Read is from registered state, so a same-cycle write is not seen.
  always_comb begin
    hit    = strobes.rdEn && validQ[rdIdx] && (tagQ[rdIdx] == rdTag);
    target = hit ? tgtQ[rdIdx] : '0;
  end

endmodule

// File: rtl/ind_tgt_pred.sv
module ind_tgt_pred
  import itp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int TGT_W  = 32,
  parameter int HIST_W = 8,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              indexByPcOnly,
  input  logic              lookupValid,
  input  logic [PC_W-1:0]   lookupPc,
  output logic              lookupHit,
  output logic [TGT_W-1:0]  lookupTarget,
  output logic [HIST_W-1:0] lookupHist,
  input  logic              updateValid,
  input  logic [PC_W-1:0]   updatePc,
  input  logic [TGT_W-1:0]  updateTarget,
  input  logic [HIST_W-1:0] updateHist,
  input  logic              condValid,
  input  logic              condTaken
);

  itpStrobes_t      strobes;
  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] wrIdx;
  logic [TAG_W-1:0] rdTag;
  logic [TAG_W-1:0] wrTag;

  itp_ctrl #(
    .PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .indexByPcOnly(indexByPcOnly),
    .lookupValid(lookupValid), .lookupPc(lookupPc),
    .updateValid(updateValid), .updatePc(updatePc), .updateHist(updateHist),
    .condValid(condValid), .condTaken(condTaken),
    .histQ(lookupHist), .rdIdx(rdIdx), .rdTag(rdTag),
    .wrIdx(wrIdx), .wrTag(wrTag), .strobes(strobes)
  );

  itp_table #(
    .TGT_W(TGT_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_table (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rdIdx(rdIdx), .rdTag(rdTag), .wrIdx(wrIdx), .wrTag(wrTag),
    .wrTarget(updateTarget), .hit(lookupHit), .target(lookupTarget)
  );

endmodule

// File: rtl/itp_checker.sv
module itp_checker #(
  parameter int PC_W   = 32,
  parameter int TGT_W  = 32,
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              indexByPcOnly,
  input logic              lookupValid,
  input logic [PC_W-1:0]   lookupPc,
  input logic              lookupHit,
  input logic [TGT_W-1:0]  lookupTarget,
  input logic [HIST_W-1:0] lookupHist,
  input logic              updateValid,
  input logic [PC_W-1:0]   updatePc,
  input logic [TGT_W-1:0]  updateTarget,
  input logic [HIST_W-1:0] updateHist,
  input logic              condValid,
  input logic              condTaken
);

  a_r1_no_hit_idle: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !lookupHit);

  a_r1_known_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({lookupHit, lookupHist}));

  a_r5_hist_shift: assert property (@(posedge clk) disable iff (!rstN)
    condValid |=> lookupHist == {$past(lookupHist[HIST_W-2:0]), $past(condTaken)});

  a_r5_hist_hold: assert property (@(posedge clk) disable iff (!rstN)
    !condValid |=> $stable(lookupHist));

  a_r4_write_visible: assert property (@(posedge clk) disable iff (!rstN)
    $past(updateValid) && lookupValid && lookupPc == $past(updatePc) &&
    lookupHist == $past(updateHist) && indexByPcOnly == $past(indexByPcOnly)
    |-> lookupHit && lookupTarget == $past(updateTarget));

endmodule

bind ind_tgt_pred itp_checker #(
  .PC_W(PC_W), .TGT_W(TGT_W), .HIST_W(HIST_W)
) u_itp_checker (
  .clk(clk), .rstN(rstN), .indexByPcOnly(indexByPcOnly),
  .lookupValid(lookupValid), .lookupPc(lookupPc), .lookupHit(lookupHit),
  .lookupTarget(lookupTarget), .lookupHist(lookupHist),
  .updateValid(updateValid), .updatePc(updatePc), .updateTarget(updateTarget),
  .updateHist(updateHist), .condValid(condValid), .condTaken(condTaken)
);

// File: tb/ind_tgt_pred_bench.sv
module ind_tgt_pred_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        indexByPcOnly = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupPc = '0;
  logic        lookupHit;
  logic [31:0] lookupTarget;
  logic [7:0]  lookupHist;
  logic        updateValid = 1'b0;
  logic [31:0] updatePc = '0;
  logic [31:0] updateTarget = '0;
  logic [7:0]  updateHist = '0;
  logic        condValid = 1'b0;
  logic        condTaken = 1'b0;

  int checks = 0;
  int failures = 0;

  // Behavioural table model keyed by row number.
  bit          mValid [int];
  int unsigned mTag   [int];
  int unsigned mTgt   [int];
  int unsigned mHist = 0;

  always #5 clk = ~clk;

  ind_tgt_pred u_ind_tgt_pred (
    .clk(clk), .rstN(rstN), .indexByPcOnly(indexByPcOnly),
    .lookupValid(lookupValid), .lookupPc(lookupPc), .lookupHit(lookupHit),
    .lookupTarget(lookupTarget), .lookupHist(lookupHist),
    .updateValid(updateValid), .updatePc(updatePc), .updateTarget(updateTarget),
    .updateHist(updateHist), .condValid(condValid), .condTaken(condTaken)
  );

  // R2 / R6 row and tag rules.
  function automatic int rowOf(int unsigned pc, int unsigned h, bit pcOnly);
    return int'(((pc >> 2) & 32'hFF) ^ (pcOnly ? 32'd0 : (h & 32'hFF)));
  endfunction

  function automatic int unsigned tagOf(int unsigned pc);
    int unsigned rest;
    int unsigned t;
    rest = ((pc >> 10) << 2) | (pc & 32'h3);
    t = 0;
    for (int i = 0; i < 24; i++) begin
      if (((rest >> i) & 1) != 0) t = t ^ (32'd1 << (i % 6));
    end
    return t;
  endfunction

  task automatic check(string rq, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Compare outputs against the model, then advance one clock and apply model updates.
  task automatic tick(string rq);
    int          r;
    bit          eHit;
    int unsigned eTgt;
    #1;
    check("R5", "history", lookupHist, mHist);
    r = rowOf(lookupPc, mHist, indexByPcOnly);
    eHit = lookupValid && mValid.exists(r) && mValid[r] && (mTag[r] == tagOf(lookupPc));
    eTgt = eHit ? mTgt[r] : 0;
    check(rq, "hit", lookupHit, eHit);
    check(rq, "target", lookupTarget, eTgt);
    @(posedge clk);
    if (rstN) begin
      if (updateValid) begin
        r = rowOf(updatePc, updateHist, indexByPcOnly);
        mValid[r] = 1'b1;
        mTag[r]   = tagOf(updatePc);
        mTgt[r]   = updateTarget;
      end
      if (condValid) mHist = ((mHist << 1) | condTaken) & 32'hFF;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    lookupValid = 0; updateValid = 0; condValid = 0;
  endtask

  task automatic pushHist(bit t);
    idle(); condValid = 1; condTaken = t; tick("R5"); condValid = 0;
  endtask

  localparam int unsigned PC_A = 32'h0000_4A10;
  localparam int unsigned PC_B = PC_A ^ 32'h0000_0400; // same row bits, other tag

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R3 / R5: empty after reset, history zero.
    lookupValid = 1; lookupPc = PC_A;
    tick("R3");
    check("R5", "reset history", lookupHist, 0);

    // R4: write then read back next cycle.
    idle(); updateValid = 1; updatePc = PC_A; updateHist = lookupHist; updateTarget = 32'h1000_0040;
    tick("R9");
    idle(); lookupValid = 1; lookupPc = PC_A;
    tick("R4");
    check("R4", "hit after write", lookupHit, 1);

    // R3: aliasing PC with other tag misses.
    lookupPc = PC_B;
    tick("R3");
    check("R3", "tag mismatch", lookupHit, 0);

    // R8: new history, new target for the same branch.
    pushHist(1); pushHist(0); pushHist(1);
    lookupValid = 1; lookupPc = PC_A;
    tick("R2");
    check("R2", "other history misses", lookupHit, 0);
    idle(); updateValid = 1; updatePc = PC_A; updateHist = 8'h05; updateTarget = 32'h2000_0080;
    tick("R8");
    idle(); lookupValid = 1; lookupPc = PC_A;
    tick("R8");
    check("R8", "second target", lookupTarget, 32'h2000_0080);
    for (int i = 0; i < 8; i++) pushHist(0);
    lookupValid = 1; lookupPc = PC_A;
    tick("R8");
    check("R8", "first target kept", lookupTarget, 32'h1000_0040);

    // R7: same-row lookup and update return old data.
    updateValid = 1; updatePc = PC_A; updateHist = 8'h00; updateTarget = 32'h3000_00C0;
    tick("R7");
    idle(); lookupValid = 1; lookupPc = PC_A;
    tick("R7");
    check("R7", "new data next cycle", lookupTarget, 32'h3000_00C0);

    // R9: inert update port.
    idle(); updatePc = PC_B; updateHist = 8'h00; updateTarget = 32'hDEAD_0000;
    tick("R9");
    lookupValid = 1; lookupPc = PC_B;
    tick("R9");
    check("R9", "no write", lookupHit, 0);

    // R6: PC-only mode ignores history.
    pushHist(1); pushHist(1);
    indexByPcOnly = 1;
    idle(); updateValid = 1; updatePc = PC_B; updateHist = 8'h5A; updateTarget = 32'h4000_0100;
    tick("R6");
    idle(); lookupValid = 1; lookupPc = PC_B;
    tick("R6");
    check("R6", "history ignored", lookupTarget, 32'h4000_0100);
    pushHist(0);
    lookupValid = 1; lookupPc = PC_B;
    tick("R6");
    check("R6", "still hits", lookupHit, 1);
    indexByPcOnly = 0;

    // Mixed random stream against the model.
    for (int n = 0; n < 600; n++) begin
      int unsigned pool [4];
      pool[0] = PC_A; pool[1] = PC_B; pool[2] = 32'h0001_2344; pool[3] = 32'h0007_7710;
      if (n == 300) indexByPcOnly = 1;
      lookupValid  = $urandom % 2;
      lookupPc     = pool[$urandom % 4];
      updateValid  = ($urandom % 3) == 0;
      updatePc     = pool[$urandom % 4];
      updateHist   = (($urandom % 2) != 0) ? lookupHist : 8'($urandom);
      updateTarget = $urandom;
      condValid    = $urandom % 2;
      condTaken    = $urandom % 2;
      tick("R1");
    end

    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule